// File: doc/BRIEF.md
# Serial Test Port with Configuration Storage

This block is a four-wire serial test port for a small programmable device. A sixteen-state controller, clocked by `tck` and steered by the level on `tms`, walks through capture, shift and update phases for either an 8-bit instruction register or one of several data registers. The instruction currently held picks which data register is placed between `tdi` and `tdo`. The choices are a 1-bit bypass stage, a 32-bit identification code, a 56-bit boundary chain, a 10-bit row address, a 90-bit configuration word and a 32-bit user signature.

Configuration is written as a sequence. First the row address is scanned in, then the 90-bit word, and then the program instruction is loaded. When the controller next enters Run-Test/Idle with that instruction current, the block copies the word into a 1024-row behavioural storage array at the addressed row. Scanning the configuration register captures the stored row at the current address, so the written contents can be read back over the same port.

Inputs are sampled on the rising edge of `tck`. `tdo` and its enable change on the falling edge. A low level on `rst_n` forces the controller to its reset state at once. Release of `rst_n` is synchronised to `tck`.

Top module: `cfg_tap`

## Requirements
- R1: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, including the middle of a data scan. The instruction then reads back as the identification code.
- R2: While `rst_n` is low, `tdo_oe` is low and the controller is held in Test-Logic-Reset. After release, a data scan returns the identification code with no instruction scan first.
- R3: Each instruction scan shifts out the captured pattern 8'h01, least significant bit first.
- R4: Opcode 8'h16 selects the 32-bit identification register. It reads 32'h1A5C_0043, least significant bit first.
- R5: Opcode 8'hFF, and every opcode not listed in these requirements (for example 8'h00 and 8'h7A), selects a 1-bit bypass stage that captures 0. Opcode 8'h03 also places the bypass stage on the path.
- R6: `tdo_oe` is high only in Shift-IR and Shift-DR. It and `tdo` change on the falling edge of `tck`, so on entry to a shift state the enable rises half a period after the rising edge.
- R7: Opcode 8'h01 selects the 10-bit address register. A scan captures the address held from the previous update, and that value changes only at Update-DR.
- R8: Opcode 8'h04 selects the 32-bit user signature register, which keeps its updated value across scans of other instructions.
- R9: Opcode 8'h05 selects the 56-bit boundary register. A scan captures the value held from the previous update.
- R10: Opcode 8'h02 selects the 90-bit configuration register. A scan captures the stored row at the current address. Updating the register without the program instruction leaves the storage unchanged.
- R11: With opcode 8'h03 current, entering Run-Test/Idle writes the last updated 90-bit configuration word into the storage row given by the address register. Other rows keep their contents.
- R12: Pause-DR holds the partly shifted contents for any number of cycles. Returning through Exit2-DR to Shift-DR resumes shifting where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised to tck |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo, high only while shifting |

## Verification
A wrong controller state shows on `tdo_oe` at the next falling edge, and on the length of the path between `tdi` and `tdo` within one scan. A wrong instruction decode shows as a shifted pattern that comes out after the wrong number of cycles. A shadow register that changes at the wrong time, or a missing or misdirected storage write, stays hidden until the next capture of that register. The bench therefore reads every register and every programmed row back in a separate scan, so any such fault appears within one later scan.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;
  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SHIFT_DR, S_EXIT1_DR, S_PAUSE_DR, S_EXIT2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SHIFT_IR, S_EXIT1_IR, S_PAUSE_IR, S_EXIT2_IR, S_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {SEL_BYP, SEL_ID, SEL_BSC, SEL_ADR, SEL_DAT, SEL_UES} dr_sel_e;

  localparam int IR_W = 8;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;
  localparam logic [IR_W-1:0] OP_IDCODE = 8'h16;
  localparam logic [IR_W-1:0] OP_ADDR   = 8'h01;
  localparam logic [IR_W-1:0] OP_DATA   = 8'h02;
  localparam logic [IR_W-1:0] OP_PROG   = 8'h03;
  localparam logic [IR_W-1:0] OP_UES    = 8'h04;
  localparam logic [IR_W-1:0] OP_BSCAN  = 8'h05;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import cfg_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_TLR:      nxt = tms ? S_TLR      : S_RTI;
      S_RTI:      nxt = tms ? S_SEL_DR   : S_RTI;
      S_SEL_DR:   nxt = tms ? S_SEL_IR   : S_CAP_DR;
      S_CAP_DR:   nxt = tms ? S_EXIT1_DR : S_SHIFT_DR;
      S_SHIFT_DR: nxt = tms ? S_EXIT1_DR : S_SHIFT_DR;
      S_EXIT1_DR: nxt = tms ? S_UPD_DR   : S_PAUSE_DR;
      S_PAUSE_DR: nxt = tms ? S_EXIT2_DR : S_PAUSE_DR;
      S_EXIT2_DR: nxt = tms ? S_UPD_DR   : S_SHIFT_DR;
      S_UPD_DR:   nxt = tms ? S_SEL_DR   : S_RTI;
      S_SEL_IR:   nxt = tms ? S_TLR      : S_CAP_IR;
      S_CAP_IR:   nxt = tms ? S_EXIT1_IR : S_SHIFT_IR;
      S_SHIFT_IR: nxt = tms ? S_EXIT1_IR : S_SHIFT_IR;
      S_EXIT1_IR: nxt = tms ? S_UPD_IR   : S_PAUSE_IR;
      S_PAUSE_IR: nxt = tms ? S_EXIT2_IR : S_PAUSE_IR;
      S_EXIT2_IR: nxt = tms ? S_UPD_IR   : S_SHIFT_IR;
      S_UPD_IR:   nxt = tms ? S_SEL_DR   : S_RTI;
      default:    nxt = S_TLR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_TLR;
    else        state <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import cfg_tap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);
  logic [IR_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= IR_CAPTURE;
      ir_q <= OP_IDCODE;
    end else begin
      if (state == S_CAP_IR)        sh_q <= IR_CAPTURE;
      else if (state == S_SHIFT_IR) sh_q <= {tdi, sh_q[IR_W-1:1]};
      if (state == S_TLR)           ir_q <= OP_IDCODE;
      else if (state == S_UPD_IR)   ir_q <= sh_q;
    end
  end

  assign ir_so = sh_q[0];
endmodule

// File: rtl/tap_dreg.sv
module tap_dreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic         update,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic         so,
  output logic [W-1:0] shadow
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      shadow <= '0;
    end else begin
      if (capture)    sh_q <= cap_val;
      else if (shift) sh_q <= {tdi, sh_q[W-1:1]};
      if (update)     shadow <= sh_q;
    end
  end

  assign so = sh_q[0];
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 90
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cfg_tap.sv
module cfg_tap
  import cfg_tap_pkg::*;
#(
  parameter logic [31:0] ID_CODE = 32'h1A5C_0043,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 90,
  parameter int BSC_W  = 56,
  parameter int UES_W  = 32
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe
);
  localparam int ID_W = 32;

  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  dr_sel_e         sel;

  tap_fsm u_fsm (.clk(tck), .rst_n(rst_q), .tms(tms), .state(state));
  tap_ir  u_ir  (.clk(tck), .rst_n(rst_q), .state(state), .tdi(tdi), .ir_q(ir_q), .ir_so(ir_so));

  always_comb begin
    case (ir_q)
      OP_IDCODE: sel = SEL_ID;
      OP_BSCAN:  sel = SEL_BSC;
      OP_ADDR:   sel = SEL_ADR;
      OP_DATA:   sel = SEL_DAT;
      OP_UES:    sel = SEL_UES;
      default:   sel = SEL_BYP;
    endcase
  end

  logic cap_dr, sft_dr, upd_dr;
  assign cap_dr = (state == S_CAP_DR);
  assign sft_dr = (state == S_SHIFT_DR);
  assign upd_dr = (state == S_UPD_DR);

  logic            byp_q;
  logic [ID_W-1:0] id_sh;
  always_ff @(posedge tck or negedge rst_q) begin
    if (!rst_q) begin
      byp_q <= 1'b0;
      id_sh <= '0;
    end else begin
      if (cap_dr && sel == SEL_BYP)      byp_q <= 1'b0;
      else if (sft_dr && sel == SEL_BYP) byp_q <= tdi;
      if (cap_dr && sel == SEL_ID)       id_sh <= ID_CODE;
      else if (sft_dr && sel == SEL_ID)  id_sh <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  logic [BSC_W-1:0]  bsc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, row_rd;
  logic [UES_W-1:0]  ues_q;
  logic bsc_so, adr_so, dat_so, ues_so;

  tap_dreg #(.W(BSC_W)) u_bsc (.clk(tck), .rst_n(rst_q), .capture(cap_dr && sel == SEL_BSC),
    .shift(sft_dr && sel == SEL_BSC), .update(upd_dr && sel == SEL_BSC), .tdi(tdi),
    .cap_val(bsc_q), .so(bsc_so), .shadow(bsc_q));
  tap_dreg #(.W(ADDR_W)) u_adr (.clk(tck), .rst_n(rst_q), .capture(cap_dr && sel == SEL_ADR),
    .shift(sft_dr && sel == SEL_ADR), .update(upd_dr && sel == SEL_ADR), .tdi(tdi),
    .cap_val(addr_q), .so(adr_so), .shadow(addr_q));
  tap_dreg #(.W(DATA_W)) u_dat (.clk(tck), .rst_n(rst_q), .capture(cap_dr && sel == SEL_DAT),
    .shift(sft_dr && sel == SEL_DAT), .update(upd_dr && sel == SEL_DAT), .tdi(tdi),
    .cap_val(row_rd), .so(dat_so), .shadow(data_q));
  tap_dreg #(.W(UES_W)) u_ues (.clk(tck), .rst_n(rst_q), .capture(cap_dr && sel == SEL_UES),
    .shift(sft_dr && sel == SEL_UES), .update(upd_dr && sel == SEL_UES), .tdi(tdi),
    .cap_val(ues_q), .so(ues_so), .shadow(ues_q));

  // program strobe: first cycle in Run-Test/Idle with the program opcode current
  logic was_rti_q, prog_we;
  always_ff @(posedge tck or negedge rst_q) begin
    if (!rst_q) was_rti_q <= 1'b0;
    else        was_rti_q <= (state == S_RTI);
  end
  assign prog_we = (state == S_RTI) && !was_rti_q && (ir_q == OP_PROG);

  cfg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (.clk(tck), .we(prog_we),
    .waddr(addr_q), .wdata(data_q), .raddr(addr_q), .rdata(row_rd));

  logic ser_bit;
  always_comb begin
    if (state == S_SHIFT_IR) ser_bit = ir_so;
    else begin
      case (sel)
        SEL_ID:  ser_bit = id_sh[0];
        SEL_BSC: ser_bit = bsc_so;
        SEL_ADR: ser_bit = adr_so;
        SEL_DAT: ser_bit = dat_so;
        SEL_UES: ser_bit = ues_so;
        default: ser_bit = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge rst_q) begin
    if (!rst_q) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= ser_bit;
      tdo_oe <= (state == S_SHIFT_IR) || (state == S_SHIFT_DR);
    end
  end
endmodule

// File: rtl/cfg_tap_chk.sv
module cfg_tap_chk
  import cfg_tap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              tck,
  input logic              rst_q,
  input logic              tms,
  input tap_state_e        state,
  input logic [IR_W-1:0]   ir_q,
  input dr_sel_e           sel,
  input logic              byp_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              prog_we,
  input logic              tdo_oe
);
  // R1
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!rst_q)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == S_TLR));

  // R2
  reset_opcode_chk: assert property (@(posedge tck) disable iff (!rst_q)
    (state == S_TLR) |=> (ir_q == OP_IDCODE));

  // R5
  bypass_capture_chk: assert property (@(posedge tck) disable iff (!rst_q)
    (state == S_CAP_DR && sel == SEL_BYP) |=> (byp_q == 1'b0));

  // R6
  enable_window_chk: assert property (@(posedge tck) disable iff (!rst_q)
    tdo_oe == (state == S_SHIFT_IR || state == S_SHIFT_DR));

  // R7
  addr_hold_chk: assert property (@(posedge tck) disable iff (!rst_q)
    (state != S_UPD_DR) |=> $stable(addr_q));

  // R11
  program_fire_chk: assert property (@(posedge tck) disable iff (!rst_q)
    (state == S_UPD_DR && ir_q == OP_PROG && !tms) |=> prog_we);
endmodule

bind cfg_tap cfg_tap_chk #(.ADDR_W(ADDR_W)) i_chk (
  .tck(tck), .rst_q(rst_q), .tms(tms), .state(state), .ir_q(ir_q), .sel(sel),
  .byp_q(byp_q), .addr_q(addr_q), .prog_we(prog_we), .tdo_oe(tdo_oe)
);

// File: tb/test_cfg_tap.sv
module test_cfg_tap;
  localparam logic [31:0] ID = 32'h1A5C_0043;
  // entries: {opcode, expected register length}
  localparam logic [15:0] VEC [8] = '{16'hFF01, 16'h1620, 16'h010A, 16'h025A,
                                      16'h0420, 16'h0538, 16'h7A01, 16'h0001};

  logic tck = 1'b0;
  logic rst_n, tms, tdi;
  logic tdo, tdo_oe;
  int n_cmp = 0, n_bad = 0;

  always #2 tck = ~tck;

  cfg_tap i_cfg_tap (.tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    o = tdo; tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_ir(input logic [7:0] op, output logic [7:0] cap);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 8; i++) begin tick(i == 7, op[i], o); cap[i] = o; end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic shift_dr(input logic [127:0] din, input int len, output logic [127:0] dout);
    logic o;
    dout = '0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < len; i++) begin tick(i == len - 1, din[i], o); dout[i] = o; end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic o;
    logic [7:0] cap;
    logic [127:0] dout;
    logic [15:0] pat;
    logic [89:0] d1, d2, d3;
    logic [31:0] u;
    logic [55:0] b;
    tms = 1; tdi = 0; rst_n = 0;
    @(negedge tck); #1;
    tick(1, 0, o); tick(1, 0, o);
    chk("R2 oe low in reset", tdo_oe, 0);
    rst_n = 1;
    repeat (3) tick(1, 0, o);
    tick(0, 0, o);
    chk("R6 oe low in idle", tdo_oe, 0);
    shift_dr('0, 32, dout);
    chk("R2 idcode after reset", dout, ID);
    shift_ir(8'h16, cap);
    chk("R3 ir capture", cap, 8'h01);
    shift_dr('0, 32, dout);
    chk("R4 idcode value", dout, ID);

    // vector table: path length per opcode (R4 R5 R7 R8 R9 R10)
    foreach (VEC[k]) begin
      logic [127:0] din;
      int len;
      len = int'(VEC[k][7:0]);
      pat = {VEC[k][15:8], 8'hC5};
      for (int i = 0; i < 128; i++) din[i] = pat[i % 16];
      shift_ir(VEC[k][15:8], cap);
      chk("R3 ir capture in table", cap, 8'h01);
      shift_dr(din, len + 16, dout);
      chk($sformatf("R5 R9 path length op %h", VEC[k][15:8]), (dout >> len) & 128'hFFFF, pat);
      if (len == 1) chk("R5 bypass captures 0", dout[0], 0);
    end

    // R7 address hold
    shift_ir(8'h01, cap);
    shift_dr(10'h2A5, 10, dout);
    shift_dr(10'h0F0, 10, dout);
    chk("R7 address readback", dout, 10'h2A5);

    // R9 boundary hold
    b = 56'hDE_AD5A_3C96_1E07;
    shift_ir(8'h05, cap);
    shift_dr(b, 56, dout);
    shift_dr(b, 56, dout);
    chk("R9 boundary readback", dout, b);

    // R11 program two rows, R10 read back
    d1 = 90'h2AB_CDEF_0123_4567_89AB_CDEF;
    d2 = 90'h155_0F0F_A5A5_3C3C_9669_1234;
    d3 = 90'h0DE_ADBE_EF00_FFEE_7711_0001;
    shift_ir(8'h01, cap); shift_dr(10'h3C1, 10, dout);
    shift_ir(8'h02, cap); shift_dr(d1, 90, dout);
    shift_ir(8'h03, cap);
    shift_ir(8'h01, cap); shift_dr(10'h005, 10, dout);
    shift_ir(8'h02, cap); shift_dr(d2, 90, dout);
    shift_ir(8'h03, cap);
    shift_ir(8'h01, cap); shift_dr(10'h3C1, 10, dout);
    shift_ir(8'h02, cap); shift_dr(d3, 90, dout);
    chk("R11 row 3C1 programmed", dout, d1);
    shift_ir(8'h01, cap); shift_dr(10'h005, 10, dout);
    shift_ir(8'h02, cap); shift_dr(d3, 90, dout);
    chk("R11 row 005 programmed", dout, d2);
    shift_dr(d3, 90, dout);
    chk("R10 no write without program", dout, d2);
    shift_ir(8'h01, cap); shift_dr(10'h3C1, 10, dout);
    shift_ir(8'h02, cap); shift_dr(d3, 90, dout);
    chk("R10 capture follows address", dout, d1);

    // R12 pause in the middle of a signature scan, R6 enable timing
    u = 32'h9E37_79B9;
    shift_ir(8'h04, cap);
    tick(1, 0, o);
    tms = 0;
    @(posedge tck); #1;
    tms = 0;
    @(negedge tck); #1;
    tms = 0;
    @(posedge tck); #1;
    chk("R6 oe still low after edge into shift", tdo_oe, 0);
    @(negedge tck); #1;
    chk("R6 oe high at falling edge", tdo_oe, 1);
    for (int i = 0; i < 16; i++) tick(i == 15, u[i], o);
    tick(0, 0, o);
    chk("R6 oe low in pause", tdo_oe, 0);
    tick(0, 0, o); tick(0, 0, o);
    tick(1, 0, o); tick(0, 0, o);
    for (int i = 16; i < 32; i++) tick(i == 31, u[i], o);
    tick(1, 0, o); tick(0, 0, o);
    shift_dr(u, 32, dout);
    chk("R12 pause resumes shift", dout, u);
    shift_ir(8'h16, cap);
    shift_ir(8'h04, cap);
    shift_dr(u, 32, dout);
    chk("R8 signature retained", dout, u);

    // R1 five ones from inside a data scan
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    tick(0, 1, o); tick(0, 0, o);
    repeat (5) tick(1, 0, o);
    chk("R6 oe low after reset walk", tdo_oe, 0);
    tick(0, 0, o);
    shift_dr('0, 32, dout);
    chk("R1 idcode after five ones", dout, ID);

    // R2 asynchronous reset in the middle of an instruction scan
    shift_ir(8'h04, cap);
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    chk("R6 oe high in shift-ir", tdo_oe, 1);
    rst_n = 0; #1;
    chk("R2 async reset drops oe", tdo_oe, 0);
    tick(1, 0, o); tick(1, 0, o);
    rst_n = 1;
    repeat (3) tick(1, 0, o);
    tick(0, 0, o);
    shift_dr('0, 32, dout);
    chk("R2 idcode after mid-scan reset", dout, ID);

    summary();
    $finish;
  end
endmodule